// File: doc/BRIEF.md
# Compact and Delayed Branch Resolver

This block settles control flow for one instruction of a 64-bit RISC core. Each cycle it receives an instruction word, the program counter, the values of the two source registers and the low bit of a floating-point register. A mode input picks between the newer encoding, which has compact branches without a delay slot, and the legacy encoding, which has only delayed branches. The block outputs the next PC, a request to write a return address to register 31, a flag that says a delay-slot instruction must run, and an error when a branch or jump sits directly after a compact branch.

Several primary opcodes are shared between encodings. The block tells the variants apart by comparing the rs and rt register indices. Compact branches fall through to PC+4 and link to PC+4. Delayed branches fall through to PC+8 and link to PC+8. Register-file access, fetch and exception delivery belong to neighbouring logic.

Field positions: opcode [31:26], rs index [25:21], rt index [20:16], imm16 [15:0], 21-bit offset [20:0], 26-bit offset [25:0]. A branch offset is sign-extended and shifted left by 2. A taken branch goes to PC+4 plus that offset.

Top module: `br_resolver`

## Requirements
- R1: Any word that matches no branch form gives next_pc = PC+4, with link_we and delay_slot low. This covers opcode 0x08 in legacy mode.
- R2: Opcodes 0x04 (rs==rt) and 0x05 (rs!=rt) are delayed branches in both modes. So are opcodes 0x06 (signed rs<=0) and 0x07 (signed rs>0) in legacy mode, or whenever the rt index is 0. For all of these, delay_slot is high. A taken branch goes to PC+4+(imm16<<2). A branch that is not taken goes to PC+8.
- R3: In legacy mode, opcodes 0x16 (rs<=0) and 0x17 (rs>0) are delayed branches. When taken, they link PC+8.
- R4: In new mode with a nonzero rt index, opcodes 0x06 and 0x07 decode by the register indices. An rs index of 0 gives a linking compact rt<=0 or rt>0. Equal indices give a linking compact rt>=0 or rt<0. Any other pair gives a non-linking compact unsigned rs>=rt or rs<rt.
- R5: In new mode, opcodes 0x16 and 0x17 follow the same index rules, but the branches do not link. They test rt<=0 or rt>0, rt>=0 or rt<0, and signed rs>=rt or rs<rt. An rt index of 0 is not a branch.
- R6: In new mode with rs index >= rt index, opcode 0x08 branches when the signed 64-bit sum rs+rt overflows, and opcode 0x18 branches when it does not.
- R7: In new mode with rs index < rt index, opcodes 0x08 and 0x18 decode as follows. An rs index of 0 gives a linking compact branch on rt==0 or rt!=0. Any other rs index gives a compact branch on rs==rt or rs!=rt.
- R8: In new mode, opcodes 0x36 and 0x3E with a nonzero rs index are compact branches on rs==0 or rs!=0, with a 21-bit offset. With rs index 0, they jump to rt+sext(imm16), and 0x3E also links PC+4.
- R9: In new mode, opcodes 0x32 and 0x3A are always taken, with a 26-bit offset. Opcode 0x3A links PC+4.
- R10: In new mode, opcode 0x11 with rs field 0x09 is a delayed branch taken when the FP bit is 0. With rs field 0x0D, it is taken when the FP bit is 1. In legacy mode, neither is a branch.
- R11: A compact branch that is not taken gives PC+4 and no delay slot. Linking happens only when the branch is taken or is an indexed jump. The link value is PC+4 for compact forms and PC+8 for delayed forms.
- R12: slot_err is high when a valid branch or jump directly follows a valid compact branch or indexed jump.
- R13: While instr_valid is low, link_we, delay_slot and slot_err stay low, and the forbidden-slot state is held.
- R14: Reset clears the forbidden-slot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| rs_val | input | 64 | Value of register rs |
| rt_val | input | 64 | Value of register rt |
| fp_lsb | input | 1 | Bit 0 of the selected FP register |
| mode_new | input | 1 | 1 = newer encoding, 0 = legacy |
| next_pc | output | 64 | Resolved next PC |
| link_we | output | 1 | Write return address to register 31 |
| link_val | output | 64 | Return address |
| delay_slot | output | 1 | Delay-slot instruction must execute |
| slot_err | output | 1 | Branch placed in a forbidden slot |

## Verification
The assertions check the following on every cycle:
- outputs stay quiet while no instruction is valid;
- the forbidden-slot state follows the decoded kind and holds across idle cycles;
- link values match PC+4 or PC+8 according to whether a delay slot runs;
- legacy opcode 0x08 never acts as a branch;
- the unconditional 26-bit branch always reaches its target.

The decode by register indices, the overflow edges in both directions and the unsigned compare against the signed compare can only be shown by the bench's vectors, which use values chosen to separate each variant. The same holds for the full sequences that raise or clear the slot error.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int XLEN  = 64;
    localparam int ILEN  = 32;
    localparam int STEP  = 4;

    typedef logic [XLEN-1:0] word_t;

    localparam logic [5:0] OP_EQ    = 6'h04;
    localparam logic [5:0] OP_NE    = 6'h05;
    localparam logic [5:0] OP_LEZ   = 6'h06;
    localparam logic [5:0] OP_GTZ   = 6'h07;
    localparam logic [5:0] OP_OVA   = 6'h08;
    localparam logic [5:0] OP_FPU   = 6'h11;
    localparam logic [5:0] OP_LEZC  = 6'h16;
    localparam logic [5:0] OP_GTZC  = 6'h17;
    localparam logic [5:0] OP_OVB   = 6'h18;
    localparam logic [5:0] OP_UNC   = 6'h32;
    localparam logic [5:0] OP_ZEQ   = 6'h36;
    localparam logic [5:0] OP_UNCL  = 6'h3A;
    localparam logic [5:0] OP_ZNE   = 6'h3E;
    localparam logic [4:0] FP_ZERO  = 5'h09;
    localparam logic [4:0] FP_ONE   = 5'h0D;

    typedef enum logic [1:0] {K_NONE, K_DELAYED, K_COMPACT, K_JIDX} kind_e;
    typedef enum logic [1:0] {OFF16, OFF21, OFF26} offsel_e;
    typedef enum logic [4:0] {
        C_ALWAYS, C_EQ, C_NE, C_LEZ_RS, C_GTZ_RS, C_LEZ_RT, C_GTZ_RT,
        C_GEZ_RT, C_LTZ_RT, C_GEU, C_LTU, C_GE, C_LT, C_OV, C_NOV,
        C_EQZ_RS, C_NEZ_RS, C_EQZ_RT, C_NEZ_RT, C_FP0, C_FP1
    } cond_e;

    typedef struct packed {
        kind_e   kind;
        cond_e   cond;
        logic    link;
        offsel_e osel;
    } dec_t;

    function automatic word_t sext(input logic [25:0] f, input int bits);
        word_t r;
        for (int i = 0; i < XLEN; i++)
            r[i] = (i < bits) ? f[i] : f[bits-1];
        return r;
    endfunction

    function automatic logic add_ovf(input word_t a, input word_t b);
        word_t s;
        s = a + b;
        return (a[XLEN-1] == b[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]);
    endfunction
endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    input  logic            mode_new,
    output dec_t            dec
);
    logic [5:0] op;
    logic [4:0] rsi, rti;
    logic       rs0, rt0, same, rs_ge;

    assign op    = instr[31:26];
    assign rsi   = instr[25:21];
    assign rti   = instr[20:16];
    assign rs0   = (rsi == '0);
    assign rt0   = (rti == '0);
    assign same  = (rsi == rti);
    assign rs_ge = (rsi >= rti);

    function automatic dec_t mk(kind_e k, cond_e c, logic l, offsel_e o);
        dec_t d;
        d.kind = k; d.cond = c; d.link = l; d.osel = o;
        return d;
    endfunction

    always_comb begin
        dec = mk(K_NONE, C_ALWAYS, 1'b0, OFF16);
        unique case (op)
            OP_EQ: dec = mk(K_DELAYED, C_EQ, 1'b0, OFF16);
            OP_NE: dec = mk(K_DELAYED, C_NE, 1'b0, OFF16);
            OP_LEZ: begin
                if (!mode_new || rt0) dec = mk(K_DELAYED, C_LEZ_RS, 1'b0, OFF16);
                else if (rs0)         dec = mk(K_COMPACT, C_LEZ_RT, 1'b1, OFF16);
                else if (same)        dec = mk(K_COMPACT, C_GEZ_RT, 1'b1, OFF16);
                else                  dec = mk(K_COMPACT, C_GEU, 1'b0, OFF16);
            end
            OP_GTZ: begin
                if (!mode_new || rt0) dec = mk(K_DELAYED, C_GTZ_RS, 1'b0, OFF16);
                else if (rs0)         dec = mk(K_COMPACT, C_GTZ_RT, 1'b1, OFF16);
                else if (same)        dec = mk(K_COMPACT, C_LTZ_RT, 1'b1, OFF16);
                else                  dec = mk(K_COMPACT, C_LTU, 1'b0, OFF16);
            end
            OP_LEZC: begin
                if (!mode_new)   dec = mk(K_DELAYED, C_LEZ_RS, 1'b1, OFF16);
                else if (rt0)    dec = mk(K_NONE, C_ALWAYS, 1'b0, OFF16);
                else if (rs0)    dec = mk(K_COMPACT, C_LEZ_RT, 1'b0, OFF16);
                else if (same)   dec = mk(K_COMPACT, C_GEZ_RT, 1'b0, OFF16);
                else             dec = mk(K_COMPACT, C_GE, 1'b0, OFF16);
            end
            OP_GTZC: begin
                if (!mode_new)   dec = mk(K_DELAYED, C_GTZ_RS, 1'b1, OFF16);
                else if (rt0)    dec = mk(K_NONE, C_ALWAYS, 1'b0, OFF16);
                else if (rs0)    dec = mk(K_COMPACT, C_GTZ_RT, 1'b0, OFF16);
                else if (same)   dec = mk(K_COMPACT, C_LTZ_RT, 1'b0, OFF16);
                else             dec = mk(K_COMPACT, C_LT, 1'b0, OFF16);
            end
            OP_OVA: if (mode_new) begin
                if (rs_ge)       dec = mk(K_COMPACT, C_OV, 1'b0, OFF16);
                else if (rs0)    dec = mk(K_COMPACT, C_EQZ_RT, 1'b1, OFF16);
                else             dec = mk(K_COMPACT, C_EQ, 1'b0, OFF16);
            end
            OP_OVB: if (mode_new) begin
                if (rs_ge)       dec = mk(K_COMPACT, C_NOV, 1'b0, OFF16);
                else if (rs0)    dec = mk(K_COMPACT, C_NEZ_RT, 1'b1, OFF16);
                else             dec = mk(K_COMPACT, C_NE, 1'b0, OFF16);
            end
            OP_ZEQ: if (mode_new) begin
                if (!rs0)        dec = mk(K_COMPACT, C_EQZ_RS, 1'b0, OFF21);
                else             dec = mk(K_JIDX, C_ALWAYS, 1'b0, OFF16);
            end
            OP_ZNE: if (mode_new) begin
                if (!rs0)        dec = mk(K_COMPACT, C_NEZ_RS, 1'b0, OFF21);
                else             dec = mk(K_JIDX, C_ALWAYS, 1'b1, OFF16);
            end
            OP_UNC:  if (mode_new) dec = mk(K_COMPACT, C_ALWAYS, 1'b0, OFF26);
            OP_UNCL: if (mode_new) dec = mk(K_COMPACT, C_ALWAYS, 1'b1, OFF26);
            OP_FPU: if (mode_new) begin
                if (rsi == FP_ZERO)     dec = mk(K_DELAYED, C_FP0, 1'b0, OFF16);
                else if (rsi == FP_ONE) dec = mk(K_DELAYED, C_FP1, 1'b0, OFF16);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
(
    input  cond_e cond,
    input  word_t rs_val,
    input  word_t rt_val,
    input  logic  fp_lsb,
    output logic  taken
);
    localparam int MSB = XLEN - 1;
    logic ovf, rs_z, rt_z;

    assign ovf  = add_ovf(rs_val, rt_val);
    assign rs_z = (rs_val == '0);
    assign rt_z = (rt_val == '0);

    always_comb begin
        unique case (cond)
            C_ALWAYS: taken = 1'b1;
            C_EQ:     taken = (rs_val == rt_val);
            C_NE:     taken = (rs_val != rt_val);
            C_LEZ_RS: taken = rs_val[MSB] || rs_z;
            C_GTZ_RS: taken = !rs_val[MSB] && !rs_z;
            C_LEZ_RT: taken = rt_val[MSB] || rt_z;
            C_GTZ_RT: taken = !rt_val[MSB] && !rt_z;
            C_GEZ_RT: taken = !rt_val[MSB];
            C_LTZ_RT: taken = rt_val[MSB];
            C_GEU:    taken = (rs_val >= rt_val);
            C_LTU:    taken = (rs_val < rt_val);
            C_GE:     taken = ($signed(rs_val) >= $signed(rt_val));
            C_LT:     taken = ($signed(rs_val) < $signed(rt_val));
            C_OV:     taken = ovf;
            C_NOV:    taken = !ovf;
            C_EQZ_RS: taken = rs_z;
            C_NEZ_RS: taken = !rs_z;
            C_EQZ_RT: taken = rt_z;
            C_NEZ_RT: taken = !rt_z;
            C_FP0:    taken = !fp_lsb;
            C_FP1:    taken = fp_lsb;
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target
    import br_pkg::*;
(
    input  dec_t            dec,
    input  logic            taken,
    input  logic [ILEN-1:0] instr,
    input  word_t           pc,
    input  word_t           rt_val,
    output word_t           next_pc,
    output word_t           link_val,
    output logic            do_link
);
    localparam int W16 = 16;
    localparam int W21 = 21;
    localparam int W26 = 26;

    word_t off, seq1, seq2, tgt, ext16;

    assign ext16 = sext(instr[25:0], W16);
    assign seq1  = pc + word_t'(STEP);
    assign seq2  = pc + word_t'(2 * STEP);

    always_comb begin
        unique case (dec.osel)
            OFF21:   off = sext(instr[25:0], W21);
            OFF26:   off = sext(instr[25:0], W26);
            default: off = ext16;
        endcase
    end

    assign tgt = seq1 + (off << 2);

    always_comb begin
        unique case (dec.kind)
            K_DELAYED: next_pc = taken ? tgt : seq2;
            K_COMPACT: next_pc = taken ? tgt : seq1;
            K_JIDX:    next_pc = rt_val + ext16;
            default:   next_pc = seq1;
        endcase
    end

    assign link_val = (dec.kind == K_DELAYED) ? seq2 : seq1;
    assign do_link  = dec.link && taken;
endmodule

// File: rtl/br_slot_track.sv
module br_slot_track (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic is_compact,
    input  logic is_branch,
    output logic flag,
    output logic err
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (valid) flag <= is_compact;
    end

    assign err = valid && flag && is_branch;
endmodule

// File: rtl/br_resolver.sv
module br_resolver
    import br_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [ILEN-1:0]  instr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic             fp_lsb,
    input  logic             mode_new,
    output logic [XLEN-1:0]  next_pc,
    output logic             link_we,
    output logic [XLEN-1:0]  link_val,
    output logic             delay_slot,
    output logic             slot_err
);
    dec_t dec;
    logic taken, do_link, is_compact, is_branch, cmp_flag;

    br_decode u_dec (.instr(instr), .mode_new(mode_new), .dec(dec));

    br_cond u_cond (
        .cond(dec.cond), .rs_val(rs_val), .rt_val(rt_val),
        .fp_lsb(fp_lsb), .taken(taken)
    );

    br_target u_tgt (
        .dec(dec), .taken(taken), .instr(instr), .pc(pc), .rt_val(rt_val),
        .next_pc(next_pc), .link_val(link_val), .do_link(do_link)
    );

    assign is_compact = (dec.kind == K_COMPACT) || (dec.kind == K_JIDX);
    assign is_branch  = (dec.kind != K_NONE);

    br_slot_track u_slot (
        .clk(clk), .rst(rst), .valid(instr_valid), .is_compact(is_compact),
        .is_branch(is_branch), .flag(cmp_flag), .err(slot_err)
    );

    assign link_we    = instr_valid && do_link;
    assign delay_slot = instr_valid && (dec.kind == K_DELAYED);
endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk
    import br_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            instr_valid,
    input logic [ILEN-1:0] instr,
    input word_t           pc,
    input logic            mode_new,
    input word_t           next_pc,
    input logic            link_we,
    input word_t           link_val,
    input logic            delay_slot,
    input logic            slot_err,
    input logic            is_compact,
    input logic            cmp_flag
);
    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!link_we && !delay_slot && !slot_err));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(cmp_flag));

    p_flag_set_r12: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && is_compact) |=> cmp_flag);

    p_flag_clr_r12: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !is_compact) |=> !cmp_flag);

    p_err_cause_r12: assert property (@(posedge clk) disable iff (rst)
        slot_err |-> (instr_valid && cmp_flag));

    p_link_compact_r11: assert property (@(posedge clk) disable iff (rst)
        (link_we && !delay_slot) |-> (link_val == pc + 64'd4));

    p_link_delayed_r3: assert property (@(posedge clk) disable iff (rst)
        (link_we && delay_slot) |-> (link_val == pc + 64'd8));

    p_legacy_plain_r1: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !mode_new && instr[31:26] == 6'h08)
            |-> (next_pc == pc + 64'd4 && !link_we && !delay_slot));

    p_uncond_r9: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && mode_new && instr[31:26] == 6'h32)
            |-> (next_pc == pc + 64'd4 + {{36{instr[25]}}, instr[25:0], 2'b00}));
endmodule

bind br_resolver br_resolver_chk u_chk (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .pc(pc),
    .mode_new(mode_new), .next_pc(next_pc), .link_we(link_we),
    .link_val(link_val), .delay_slot(delay_slot), .slot_err(slot_err),
    .is_compact(is_compact), .cmp_flag(cmp_flag)
);

// File: tb/br_resolver_bench.sv
`timescale 1ns/1ps
module br_resolver_bench;
    localparam int PERIOD = 20;
    localparam int NV = 28;
    localparam logic [63:0] PC0  = 64'h1000;
    localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

    typedef struct packed {
        logic [3:0]  rq;
        logic        mode;
        logic [31:0] ins;
        logic [63:0] rs;
        logic [63:0] rt;
        logic        fp;
        logic [63:0] nxt;
        logic        lwe;
        logic [63:0] lnk;
        logic        ds;
    } vec_t;

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] b, input logic [15:0] im);
        return {op, a, b, im};
    endfunction
    function automatic logic [31:0] mk21(input logic [5:0] op, input logic [4:0] a,
                                         input logic [20:0] o);
        return {op, a, o};
    endfunction
    function automatic logic [31:0] mk26(input logic [5:0] op, input logic [25:0] o);
        return {op, o};
    endfunction

    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0, mk(6'h08,5'd2,5'd3,16'h0010), 64'd1, 64'd1, 1'b0, 64'h1004, 1'b0, 64'h0, 1'b0}, // R1
        '{4'd2,  1'b1, mk(6'h04,5'd5,5'd6,16'h0010), 64'd7, 64'd7, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b1}, // R2
        '{4'd2,  1'b1, mk(6'h05,5'd5,5'd6,16'h0010), 64'd7, 64'd7, 1'b0, 64'h1008, 1'b0, 64'h0, 1'b1}, // R2
        '{4'd2,  1'b1, mk(6'h06,5'd2,5'd0,16'h0010), NEG1, 64'd0, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b1}, // R2
        '{4'd3,  1'b0, mk(6'h17,5'd2,5'd0,16'hFFFE), 64'd5, 64'd0, 1'b0, 64'h0FFC, 1'b1, 64'h1008, 1'b1}, // R3
        '{4'd3,  1'b0, mk(6'h16,5'd2,5'd0,16'h0010), 64'd5, 64'd0, 1'b0, 64'h1008, 1'b0, 64'h0, 1'b1}, // R3
        '{4'd4,  1'b1, mk(6'h06,5'd0,5'd3,16'h0010), 64'd9, 64'd0, 1'b0, 64'h1044, 1'b1, 64'h1004, 1'b0}, // R4
        '{4'd4,  1'b1, mk(6'h07,5'd4,5'd4,16'h0010), NEG1, NEG1, 1'b0, 64'h1044, 1'b1, 64'h1004, 1'b0}, // R4
        '{4'd4,  1'b1, mk(6'h06,5'd2,5'd3,16'h0010), NEG1, 64'd5, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b0}, // R4
        '{4'd11, 1'b1, mk(6'h07,5'd2,5'd3,16'h0010), NEG1, 64'd5, 1'b0, 64'h1004, 1'b0, 64'h0, 1'b0}, // R11
        '{4'd5,  1'b1, mk(6'h16,5'd2,5'd3,16'h0010), NEG1, 64'd5, 1'b0, 64'h1004, 1'b0, 64'h0, 1'b0}, // R5
        '{4'd5,  1'b1, mk(6'h17,5'd2,5'd3,16'h0010), NEG1, 64'd5, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b0}, // R5
        '{4'd5,  1'b1, mk(6'h16,5'd2,5'd0,16'h0010), NEG1, 64'd0, 1'b0, 64'h1004, 1'b0, 64'h0, 1'b0}, // R5
        '{4'd6,  1'b1, mk(6'h08,5'd5,5'd3,16'h0010), MAXP, 64'd1, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b0}, // R6
        '{4'd6,  1'b1, mk(6'h18,5'd5,5'd3,16'h0010), MAXP, 64'd1, 1'b0, 64'h1004, 1'b0, 64'h0, 1'b0}, // R6
        '{4'd6,  1'b1, mk(6'h18,5'd5,5'd3,16'h0010), NEG1, 64'd1, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b0}, // R6
        '{4'd6,  1'b1, mk(6'h08,5'd5,5'd3,16'h0010), MINN, NEG1, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b0}, // R6
        '{4'd7,  1'b1, mk(6'h08,5'd0,5'd3,16'h0010), 64'd4, 64'd0, 1'b0, 64'h1044, 1'b1, 64'h1004, 1'b0}, // R7
        '{4'd7,  1'b1, mk(6'h18,5'd2,5'd3,16'h0010), 64'd9, 64'd9, 1'b0, 64'h1004, 1'b0, 64'h0, 1'b0}, // R7
        '{4'd8,  1'b1, mk21(6'h36,5'd4,21'h1FFFFF), 64'd0, 64'd0, 1'b0, 64'h1000, 1'b0, 64'h0, 1'b0}, // R8
        '{4'd8,  1'b1, mk(6'h36,5'd0,5'd7,16'hFFF0), 64'd0, 64'h2000, 1'b0, 64'h1FF0, 1'b0, 64'h0, 1'b0}, // R8
        '{4'd8,  1'b1, mk(6'h3E,5'd0,5'd7,16'h0008), 64'd0, 64'h2000, 1'b0, 64'h2008, 1'b1, 64'h1004, 1'b0}, // R8
        '{4'd8,  1'b1, mk21(6'h3E,5'd4,21'h000010), 64'd3, 64'd0, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b0}, // R8
        '{4'd9,  1'b1, mk26(6'h32,26'h0000100), 64'd0, 64'd0, 1'b0, 64'h1404, 1'b0, 64'h0, 1'b0}, // R9
        '{4'd9,  1'b1, mk26(6'h3A,26'h3FFFFFF), 64'd0, 64'd0, 1'b0, 64'h1000, 1'b1, 64'h1004, 1'b0}, // R9
        '{4'd10, 1'b1, mk(6'h11,5'h09,5'd2,16'h0010), 64'd0, 64'd0, 1'b0, 64'h1044, 1'b0, 64'h0, 1'b1}, // R10
        '{4'd10, 1'b1, mk(6'h11,5'h0D,5'd2,16'h0010), 64'd0, 64'd0, 1'b0, 64'h1008, 1'b0, 64'h0, 1'b1}, // R10
        '{4'd10, 1'b0, mk(6'h11,5'h09,5'd2,16'h0010), 64'd0, 64'd0, 1'b0, 64'h1004, 1'b0, 64'h0, 1'b0}  // R10
    };

    logic clk = 1'b0, rst = 1'b1, instr_valid = 1'b0, fp_lsb = 1'b0, mode_new = 1'b1;
    logic [31:0] instr = '0;
    logic [63:0] pc = PC0, rs_val = '0, rt_val = '0;
    logic [63:0] next_pc, link_val;
    logic link_we, delay_slot, slot_err;
    int checks = 0, errors = 0;

    always #(PERIOD/2) clk = ~clk;

    br_resolver u_br_resolver (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .pc(pc),
        .rs_val(rs_val), .rt_val(rt_val), .fp_lsb(fp_lsb), .mode_new(mode_new),
        .next_pc(next_pc), .link_we(link_we), .link_val(link_val),
        .delay_slot(delay_slot), .slot_err(slot_err)
    );

    task automatic check(input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] w);
        @(negedge clk);
        instr_valid = v; instr = w; mode_new = 1'b1; pc = PC0;
        rs_val = 64'd1; rt_val = 64'd1; fp_lsb = 1'b0;
        #5;
    endtask

    localparam logic [31:0] W_BC   = {6'h32, 26'h10};
    localparam logic [31:0] W_BALC = {6'h3A, 26'h10};
    localparam logic [31:0] W_BEQ  = {6'h04, 5'd1, 5'd2, 16'h10};
    localparam logic [31:0] W_JIC  = {6'h36, 5'd0, 5'd2, 16'h10};
    localparam logic [31:0] W_PLN  = {6'h09, 5'd1, 5'd2, 16'h10};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R14: state after reset
        drive(1'b1, W_BEQ);
        check(slot_err == 1'b0, "R14 no slot error after reset", 64'(slot_err), 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr_valid = 1'b1; mode_new = VECS[i].mode; instr = VECS[i].ins;
            rs_val = VECS[i].rs; rt_val = VECS[i].rt; fp_lsb = VECS[i].fp; pc = PC0;
            #5;
            check(next_pc == VECS[i].nxt, $sformatf("R%0d next_pc vec %0d", VECS[i].rq, i),
                  next_pc, VECS[i].nxt);
            check(link_we == VECS[i].lwe, $sformatf("R%0d link_we vec %0d", VECS[i].rq, i),
                  64'(link_we), 64'(VECS[i].lwe));
            if (VECS[i].lwe)
                check(link_val == VECS[i].lnk, $sformatf("R%0d link_val vec %0d", VECS[i].rq, i),
                      link_val, VECS[i].lnk);
            check(delay_slot == VECS[i].ds, $sformatf("R%0d delay_slot vec %0d", VECS[i].rq, i),
                  64'(delay_slot), 64'(VECS[i].ds));
        end

        // R12: branch right after compact branch
        drive(1'b1, W_BC);
        drive(1'b1, W_BEQ);
        check(slot_err == 1'b1, "R12 branch after compact", 64'(slot_err), 64'd1);
        // R12: plain instruction in between clears it
        drive(1'b1, W_BC);
        drive(1'b1, W_PLN);
        check(slot_err == 1'b0, "R12 plain after compact", 64'(slot_err), 64'd0);
        drive(1'b1, W_BEQ);
        check(slot_err == 1'b0, "R12 branch after plain", 64'(slot_err), 64'd0);
        // R12: delayed branch then branch
        drive(1'b1, W_BEQ);
        check(slot_err == 1'b0, "R12 branch after delayed", 64'(slot_err), 64'd0);
        // R12: indexed jump also guards its slot
        drive(1'b1, W_JIC);
        drive(1'b1, W_BEQ);
        check(slot_err == 1'b1, "R12 branch after indexed jump", 64'(slot_err), 64'd1);
        // R13: idle cycles are quiet and keep the state
        drive(1'b1, W_BC);
        drive(1'b0, W_BALC);
        check(link_we == 1'b0, "R13 no link while idle", 64'(link_we), 64'd0);
        check(slot_err == 1'b0, "R13 no error while idle", 64'(slot_err), 64'd0);
        drive(1'b0, {6'h04, 26'h0});
        check(delay_slot == 1'b0, "R13 no delay slot while idle", 64'(delay_slot), 64'd0);
        drive(1'b1, W_BEQ);
        check(slot_err == 1'b1, "R13 state held across idle", 64'(slot_err), 64'd1);
        // R14: reset clears pending state
        drive(1'b1, W_BC);
        @(negedge clk) rst = 1'b1; instr_valid = 1'b0;
        @(negedge clk) rst = 1'b0;
        drive(1'b1, W_BEQ);
        check(slot_err == 1'b0, "R14 reset clears slot state", 64'(slot_err), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule